// File: doc/BRIEF.md
# Cache Tag ECC Error Monitor

This block sits beside the tag array of an 8-way set-associative cache. On each tag probe it receives the eight stored tag codewords of the probed set. Each codeword is a 19-bit tag entry (valid, dirty, lock and 16 address bits) plus a 6-bit single-error-correct, double-error-detect check field. All eight ways are decoded in parallel. A single flipped bit is repaired in the tag values handed back to the cache, and an uncorrectable pair of flips is flagged.

Error flags are summarised over all eight ways. The diagnostic capture is narrower: the syndrome and way number are recorded only for the way that hit, or for the way named by a debug select when force-hit is on. The failing set index is recorded for every error. A double-bit event takes over a held single-bit capture. A single-bit event never replaces anything still held. Flags are sticky and are cleared by writing one. Two interrupt lines follow their flags, each gated by its own enable. A global enable turns checking off altogether.

Top module: `tecc_monitor`

## Requirements
- R1: Codeword layout is {chk[5:0], data[18:0]}. Data bit j sits at the (j+1)-th non-power-of-two position of the range 1..24. chk[k], for k=0..4, is the XOR of the data bits whose position has bit k set. chk[5] makes the XOR of all 25 bits zero. A clean codeword raises no flag and its data is returned unchanged.
- R2: `fix_vld` is high exactly one cycle after `probe_vld`. `fix_tags` then carries the decoded data of way w in bits [19w+18:19w] and holds until the next probe.
- R3: The syndrome is {XOR of all 25 received bits, recomputed chk[4:0] XOR stored chk[4:0]}. A way whose syndrome bit 5 is 1 has a single error. Its data bit at the position given by syndrome[4:0] is inverted in `fix_tags`, and the single-error flag (status bit 0) sets.
- R4: A way whose syndrome bit 5 is 0 and whose syndrome[4:0] is nonzero has a double error. This sets the double-error flag (status bit 1), and its data passes through uncorrected.
- R5: The captured syndrome (status[13:8]) is the syndrome of the hit way, or zero when there is no hit or the hit way is clean. The captured way (status[7:5]) is the hit way when that syndrome is nonzero, and zero otherwise.
- R6: Every capture records the 11-bit probe index: bits [9:0] go to status[24:15] and bit 10 goes to status[14].
- R7: A double-error probe captures unless a double-error flag is already held. A single-error probe with no double error captures only when no flag is held.
- R8: Writing with `cfg_wdata` bit 0 (or bit 1) set clears the single (or double) flag. A new error in the same cycle wins and leaves the flag set.
- R9: `irq_sbe` equals status bit 0 AND the single-error enable (status bit 3). `irq_dbe` equals status bit 1 AND the double-error enable (status bit 4).
- R10: A write loads `cfg_wdata[4:2]` into the check enable, single enable and double enable (status bits 2, 3, 4). With the check enable at 0, no flag sets and no data is corrected.
- R11: With `dbg_force_hit` high, capture uses `dbg_way` as the hit way whatever `probe_hit` says.
- R12: After reset every status bit, both interrupts, `fix_vld` and `fix_tags` are zero.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_vld | input | 1 | Tag probe strobe |
| probe_idx | input | 11 | Probed set index |
| probe_cw | input | 200 | Eight 25-bit stored codewords, way w at [25w+24:25w] |
| probe_hit | input | 1 | Probe hit one of the ways |
| probe_hit_way | input | 3 | Way that hit |
| dbg_force_hit | input | 1 | Debug: take hit way from dbg_way |
| dbg_way | input | 3 | Debug hit-way select |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Bits 0/1 clear flags, bits 4:2 load enables |
| fix_vld | output | 1 | Corrected tags valid |
| fix_tags | output | 152 | Corrected 19-bit tags of all ways |
| status | output | 25 | Flags, enables and capture fields |
| irq_sbe | output | 1 | Single-error interrupt |
| irq_dbe | output | 1 | Double-error interrupt |

## Verification
The hardest situations to reach from the ports are the capture-priority cases. One is a double error landing on a held single capture. Another is a single error arriving while a double capture is held. A third is a clear that coincides with a new error. Directed probes build each of these orderings explicitly, with injected flips placed in hit and non-hit ways and under force-hit. A long random phase then mixes random one- and two-bit flips per way, random hits and random clear writes, while a behavioural model checks every output on every cycle.

// File: rtl/tecc_pkg.sv
package tecc_pkg;
  localparam int TAG_W = 19;
  localparam int HAM_W = 5;
  localparam int CHK_W = 6;
  localparam int CW_W  = TAG_W + CHK_W;

  // position (1..24) of data bit j inside the Hamming block
  function automatic logic [HAM_W-1:0] pos_of(input int j);
    logic [HAM_W-1:0] r;
    int n;
    r = '0;
    n = 0;
    for (int p = 1; p < 32; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j) r = p[HAM_W-1:0];
        n++;
      end
    end
    return r;
  endfunction

  // Hamming parity bits over the data field
  function automatic logic [HAM_W-1:0] ham_bits(input logic [TAG_W-1:0] d);
    logic [HAM_W-1:0] c;
    logic [HAM_W-1:0] ps;
    c = '0;
    for (int j = 0; j < TAG_W; j++) begin
      ps = pos_of(j);
      for (int k = 0; k < HAM_W; k++)
        if (ps[k]) c[k] = c[k] ^ d[j];
    end
    return c;
  endfunction
endpackage

// File: rtl/tecc_way_dec.sv
module tecc_way_dec
  import tecc_pkg::*;
(
  input  logic [CW_W-1:0]  cw,
  input  logic             en,
  output logic [TAG_W-1:0] fixed,
  output logic [CHK_W-1:0] syn,
  output logic             sbe,
  output logic             dbe
);
  logic [TAG_W-1:0] data;
  logic [CHK_W-1:0] chk;
  logic [CHK_W-1:0] raw_syn;

  assign data = cw[TAG_W-1:0];
  assign chk  = cw[CW_W-1:TAG_W];

  always_comb begin
    raw_syn[HAM_W-1:0] = ham_bits(data) ^ chk[HAM_W-1:0];
    raw_syn[CHK_W-1]   = ^cw;
  end

  assign sbe = en & raw_syn[CHK_W-1];
  assign dbe = en & ~raw_syn[CHK_W-1] & (|raw_syn[HAM_W-1:0]);
  assign syn = en ? raw_syn : '0;

  for (genvar j = 0; j < TAG_W; j++) begin : g_fix
    localparam logic [HAM_W-1:0] POS = pos_of(j);
    assign fixed[j] = data[j] ^ (sbe && (raw_syn[HAM_W-1:0] == POS));
  end
endmodule

// File: rtl/tecc_status.sv
module tecc_status
  import tecc_pkg::*;
#(
  parameter int WAY_W    = 3,
  parameter int IDX_LO_W = 10,
  parameter int CFG_W    = 5,
  parameter int ST_W     = 5 + WAY_W + CHK_W + 1 + IDX_LO_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                evt_vld,
  input  logic                evt_sbe,
  input  logic                evt_dbe,
  input  logic [IDX_LO_W:0]   evt_idx,
  input  logic [CHK_W-1:0]    evt_syn,
  input  logic [WAY_W-1:0]    evt_way,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [ST_W-1:0]     status
);
  localparam int WAY_LSB = 5;
  localparam int SYN_LSB = WAY_LSB + WAY_W;
  localparam int IDXU_B  = SYN_LSB + CHK_W;
  localparam int IDXL_LSB = IDXU_B + 1;

  logic               sbe_f, dbe_f, en_q, sie_q, die_q;
  logic [WAY_W-1:0]   way_q;
  logic [CHK_W-1:0]   syn_q;
  logic [IDX_LO_W:0]  idx_q;
  logic               keep_s, keep_d, new_s, new_d, cap;

  always_comb begin
    keep_s = sbe_f & ~(cfg_we & cfg_wdata[0]);
    keep_d = dbe_f & ~(cfg_we & cfg_wdata[1]);
    new_s  = evt_vld & evt_sbe;
    new_d  = evt_vld & evt_dbe;
    cap    = (new_d & ~keep_d) | (new_s & ~new_d & ~keep_s & ~keep_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sbe_f <= 1'b0;
      dbe_f <= 1'b0;
      en_q  <= 1'b0;
      sie_q <= 1'b0;
      die_q <= 1'b0;
      way_q <= '0;
      syn_q <= '0;
      idx_q <= '0;
    end else begin
      sbe_f <= keep_s | new_s;
      dbe_f <= keep_d | new_d;
      if (cfg_we) begin
        en_q  <= cfg_wdata[2];
        sie_q <= cfg_wdata[3];
        die_q <= cfg_wdata[4];
      end
      if (cap) begin
        way_q <= evt_way;
        syn_q <= evt_syn;
        idx_q <= evt_idx;
      end
    end
  end

  always_comb begin
    status = '0;
    status[0] = sbe_f;
    status[1] = dbe_f;
    status[2] = en_q;
    status[3] = sie_q;
    status[4] = die_q;
    status[WAY_LSB +: WAY_W]    = way_q;
    status[SYN_LSB +: CHK_W]    = syn_q;
    status[IDXU_B]              = idx_q[IDX_LO_W];
    status[IDXL_LSB +: IDX_LO_W] = idx_q[IDX_LO_W-1:0];
  end
endmodule

// File: rtl/tecc_monitor.sv
module tecc_monitor
  import tecc_pkg::*;
#(
  parameter int WAYS     = 8,
  parameter int IDX_LO_W = 10,
  parameter int WAY_W    = $clog2(WAYS),
  parameter int CFG_W    = 5,
  parameter int ST_W     = 5 + WAY_W + CHK_W + 1 + IDX_LO_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    probe_vld,
  input  logic [IDX_LO_W:0]       probe_idx,
  input  logic [WAYS*CW_W-1:0]    probe_cw,
  input  logic                    probe_hit,
  input  logic [WAY_W-1:0]        probe_hit_way,
  input  logic                    dbg_force_hit,
  input  logic [WAY_W-1:0]        dbg_way,
  input  logic                    cfg_we,
  input  logic [CFG_W-1:0]        cfg_wdata,
  output logic                    fix_vld,
  output logic [WAYS*TAG_W-1:0]   fix_tags,
  output logic [ST_W-1:0]         status,
  output logic                    irq_sbe,
  output logic                    irq_dbe
);
  logic [WAYS*TAG_W-1:0] fix_w;
  logic [CHK_W-1:0]      syn_w [WAYS];
  logic [WAYS-1:0]       sbe_w, dbe_w;
  logic                  ecc_en;
  logic                  eff_hit;
  logic [WAY_W-1:0]      sel_way, cap_way;
  logic [CHK_W-1:0]      hit_syn;

  assign ecc_en = status[2];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tecc_way_dec u_dec (
      .cw    (probe_cw[w*CW_W +: CW_W]),
      .en    (ecc_en),
      .fixed (fix_w[w*TAG_W +: TAG_W]),
      .syn   (syn_w[w]),
      .sbe   (sbe_w[w]),
      .dbe   (dbe_w[w])
    );
  end

  always_comb begin
    eff_hit = dbg_force_hit | probe_hit;
    sel_way = dbg_force_hit ? dbg_way : probe_hit_way;
    hit_syn = eff_hit ? syn_w[sel_way] : '0;
    cap_way = (hit_syn != '0) ? sel_way : '0;
  end

  tecc_status #(
    .WAY_W    (WAY_W),
    .IDX_LO_W (IDX_LO_W),
    .CFG_W    (CFG_W),
    .ST_W     (ST_W)
  ) u_status (
    .clk       (clk),
    .rst       (rst),
    .evt_vld   (probe_vld),
    .evt_sbe   (|sbe_w),
    .evt_dbe   (|dbe_w),
    .evt_idx   (probe_idx),
    .evt_syn   (hit_syn),
    .evt_way   (cap_way),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .status    (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_vld  <= 1'b0;
      fix_tags <= '0;
    end else begin
      fix_vld <= probe_vld;
      if (probe_vld) fix_tags <= fix_w;
    end
  end

  assign irq_sbe = status[0] & status[3];
  assign irq_dbe = status[1] & status[4];
endmodule

// File: rtl/tecc_monitor_chk.sv
module tecc_monitor_chk #(
  parameter int WAY_W = 3,
  parameter int CHK_W = 6,
  parameter int CAP_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             probe_vld,
  input logic             fix_vld,
  input logic             sbe_f,
  input logic             dbe_f,
  input logic             ecc_en,
  input logic [CAP_W-1:0] cap,
  input logic             cfg_we,
  input logic [1:0]       clr
);
  // R2
  fix_vld_follows_chk: assert property (@(posedge clk) disable iff (rst)
    probe_vld |=> fix_vld);
  // R2
  fix_vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !probe_vld |=> !fix_vld);
  // R8
  sbe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sbe_f && !(cfg_we && clr[0])) |=> sbe_f);
  // R7
  dbe_capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dbe_f && !(cfg_we && clr[1])) |=> $stable(cap));
  // R5
  way_needs_syn_chk: assert property (@(posedge clk) disable iff (rst)
    (cap[WAY_W-1:0] != '0) |-> (cap[WAY_W +: CHK_W] != '0));
  // R10
  sbe_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sbe_f) |-> $past(ecc_en));
  // R3
  sbe_needs_probe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sbe_f) |-> $past(probe_vld));
endmodule

bind tecc_monitor tecc_monitor_chk #(
  .WAY_W (WAY_W),
  .CHK_W (tecc_pkg::CHK_W),
  .CAP_W (ST_W - 5)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .probe_vld (probe_vld),
  .fix_vld   (fix_vld),
  .sbe_f     (status[0]),
  .dbe_f     (status[1]),
  .ecc_en    (status[2]),
  .cap       (status[ST_W-1:5]),
  .cfg_we    (cfg_we),
  .clr       (cfg_wdata[1:0])
);

// File: tb/tecc_monitor_tb.sv
module tecc_monitor_tb;
  localparam int WAYS = 8, WAY_W = 3, IDX_LO_W = 10;
  localparam int TAG_W = 19, CW_W = 25, ST_W = 25;

  logic clk = 1'b0, rst = 1'b1;
  logic probe_vld = 0, probe_hit = 0, dbg_force_hit = 0, cfg_we = 0;
  logic [IDX_LO_W:0] probe_idx = '0;
  logic [WAYS*CW_W-1:0] probe_cw = '0;
  logic [WAY_W-1:0] probe_hit_way = '0, dbg_way = '0;
  logic [4:0] cfg_wdata = '0;
  logic fix_vld, irq_sbe, irq_dbe;
  logic [WAYS*TAG_W-1:0] fix_tags;
  logic [ST_W-1:0] status;

  int checks = 0, fails = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  tecc_monitor u_dut (
    .clk(clk), .rst(rst), .probe_vld(probe_vld), .probe_idx(probe_idx),
    .probe_cw(probe_cw), .probe_hit(probe_hit), .probe_hit_way(probe_hit_way),
    .dbg_force_hit(dbg_force_hit), .dbg_way(dbg_way), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .fix_vld(fix_vld), .fix_tags(fix_tags),
    .status(status), .irq_sbe(irq_sbe), .irq_dbe(irq_dbe)
  );

  // ---------- code from the requirement text ----------
  function automatic int bpos(input int j);
    int p = 0, cnt = -1;
    while (cnt < j) begin
      p++;
      if ($countones(p) != 1) cnt++;
    end
    return p;
  endfunction

  function automatic logic [24:0] enc(input logic [18:0] d);
    logic [5:0] c = '0;
    for (int k = 0; k < 5; k++)
      for (int j = 0; j < 19; j++)
        if (((bpos(j) >> k) & 1) == 1) c[k] = c[k] ^ d[j];
    c[5] = ^{d, c[4:0]};
    return {c, d};
  endfunction

  // kind: 0 clean, 1 single, 2 double
  function automatic void classify(input logic [24:0] cw, output int kind,
                                   output logic [18:0] fixed, output logic [5:0] syn);
    logic [24:0] ref_cw = enc(cw[18:0]);
    syn = {^cw, ref_cw[23:19] ^ cw[23:19]};
    fixed = cw[18:0];
    if (syn == 0) kind = 0;
    else if (syn[5]) begin
      kind = 1;
      for (int b = 0; b < 25; b++) begin
        logic [24:0] t = cw ^ (25'd1 << b);
        if (enc(t[18:0]) == t && b < 19) fixed = t[18:0];
      end
    end else kind = 2;
  endfunction

  // ---------- behavioural reference model ----------
  logic m_sbe, m_dbe, m_en, m_sie, m_die, m_fvld;
  logic [2:0] m_way; logic [5:0] m_syn; logic [10:0] m_idx;
  logic [WAYS*TAG_W-1:0] m_ftags;

  function automatic logic [ST_W-1:0] m_status();
    return {m_idx[9:0], m_idx[10], m_syn, m_way, m_die, m_sie, m_en, m_dbe, m_sbe};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_sbe, m_dbe, m_en, m_sie, m_die, m_fvld} = '0;
      m_way = 0; m_syn = 0; m_idx = 0; m_ftags = '0;
    end else begin
      int kind; logic [18:0] fx; logic [5:0] sy;
      logic any_s, any_d, hs, hd, eff;
      logic [5:0] hsyn; logic [2:0] sw;
      logic [WAYS*TAG_W-1:0] nt;
      logic [5:0] wsyn [WAYS];
      any_s = 0; any_d = 0; nt = '0;
      for (int w = 0; w < WAYS; w++) begin
        classify(probe_cw[w*CW_W +: CW_W], kind, fx, sy);
        if (!m_en) begin kind = 0; sy = 0; fx = probe_cw[w*CW_W +: 19]; end
        if (kind == 2) fx = probe_cw[w*CW_W +: 19];
        wsyn[w] = sy;
        nt[w*TAG_W +: TAG_W] = fx;
        if (kind == 1) any_s = 1;
        if (kind == 2) any_d = 1;
      end
      eff = dbg_force_hit || probe_hit;
      sw = dbg_force_hit ? dbg_way : probe_hit_way;
      hsyn = eff ? wsyn[sw] : 6'd0;
      hs = m_sbe && !(cfg_we && cfg_wdata[0]);
      hd = m_dbe && !(cfg_we && cfg_wdata[1]);
      any_s = any_s && probe_vld;
      any_d = any_d && probe_vld;
      if ((any_d && !hd) || (any_s && !any_d && !hs && !hd)) begin
        m_syn = hsyn; m_way = (hsyn != 0) ? sw : 3'd0; m_idx = probe_idx;
      end
      m_sbe = hs || any_s;
      m_dbe = hd || any_d;
      if (cfg_we) begin m_en = cfg_wdata[2]; m_sie = cfg_wdata[3]; m_die = cfg_wdata[4]; end
      m_fvld = probe_vld;
      if (probe_vld) m_ftags = nt;
    end
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [ST_W-1:0] ms;
  always @(negedge clk) if (cmp_on) begin
    ms = m_status();
    chk("R2 fix_vld", fix_vld, m_fvld);
    chk("R3 fix_tags", fix_tags, m_ftags);
    chk("R3 sbe flag", status[0], ms[0]);
    chk("R4 dbe flag", status[1], ms[1]);
    chk("R5 syn/way", status[13:5], ms[13:5]);
    chk("R6 index", status[24:14], ms[24:14]);
    chk("R10 enables", status[4:2], ms[4:2]);
    chk("R9 irqs", {irq_dbe, irq_sbe}, {m_dbe & m_die, m_sbe & m_sie});
  end

  // ---------- stimulus helpers ----------
  task automatic set_way(input int w, input logic [18:0] d, input logic [24:0] m);
    probe_cw[w*CW_W +: CW_W] = enc(d) ^ m;
  endtask

  task automatic clean_all();
    for (int w = 0; w < WAYS; w++) set_way(w, 19'($urandom), '0);
  endtask

  task automatic probe(input logic [10:0] idx, input logic hit, input logic [2:0] hw,
                       input logic force_h, input logic [2:0] dw);
    @(negedge clk);
    probe_vld = 1; probe_idx = idx; probe_hit = hit; probe_hit_way = hw;
    dbg_force_hit = force_h; dbg_way = dw;
    @(negedge clk);
    probe_vld = 0; dbg_force_hit = 0;
  endtask

  task automatic wr(input logic [4:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [18:0] d0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset status", status, '0);
    chk("R12 reset outputs", {fix_vld, irq_sbe, irq_dbe, fix_tags}, '0);
    cmp_on = 1;

    wr(5'b11100);
    // R1 clean probe
    clean_all(); d0 = 19'h5_1234; set_way(2, d0, '0);
    probe(11'h123, 1, 2, 0, 0);
    chk("R1 clean flags", status[1:0], 2'b00);
    chk("R1 clean data", fix_tags[2*TAG_W +: TAG_W], d0);

    // R3 single in hit way 5, index with upper bit set
    clean_all(); d0 = 19'h2_AB0F; set_way(5, d0, 25'd1 << 7);
    probe(11'h5A5, 1, 5, 0, 0);
    chk("R3 corrected", fix_tags[5*TAG_W +: TAG_W], d0);
    chk("R3 way", status[7:5], 3'd5);
    chk("R6 index", status[24:14], {10'h1A5, 1'b1});
    chk("R9 irq_sbe", irq_sbe, 1'b1);

    // R7 second single does not replace
    clean_all(); set_way(1, 19'h1, 25'd1 << 20);
    probe(11'h011, 1, 0, 0, 0);
    chk("R7 sbe keeps capture", status[24:14], {10'h1A5, 1'b1});

    // R8 clear
    wr(5'b11101);
    chk("R8 cleared", {status[0], irq_sbe}, 2'b00);

    // R5 single in non-hit way
    clean_all(); set_way(3, 19'h7_0000, 25'd1 << 2);
    probe(11'h040, 1, 1, 0, 0);
    chk("R5 non-hit syn", status[13:5], '0);

    // R7 double overwrites single capture
    clean_all(); d0 = 19'h0_F0F0; set_way(6, d0, (25'd1 << 3) | (25'd1 << 11));
    probe(11'h2AA, 1, 6, 0, 0);
    chk("R7 dbe capture idx", status[24:14], {10'h2AA, 1'b0});
    chk("R4 raw data", fix_tags[6*TAG_W +: TAG_W], d0 ^ 19'h808);
    chk("R9 irq_dbe", irq_dbe, 1'b1);

    // R7 single and second double keep the double capture
    clean_all(); set_way(0, 19'h3, 25'd1 << 0);
    probe(11'h001, 1, 0, 0, 0);
    clean_all(); set_way(4, 19'h3, 25'd3);
    probe(11'h002, 1, 4, 0, 0);
    chk("R7 held dbe", status[24:14], {10'h2AA, 1'b0});

    // R8 clear and new error in same cycle: set wins
    clean_all(); set_way(7, 19'h9, 25'd1 << 15);
    @(negedge clk);
    probe_vld = 1; probe_idx = 11'h333; probe_hit = 0; cfg_we = 1; cfg_wdata = 5'b11111;
    @(negedge clk);
    probe_vld = 0; cfg_we = 0;
    chk("R8 set wins", status[1:0], 2'b01);
    chk("R8 capture after clear", status[24:14], {10'h333, 1'b0});

    // R10 checking disabled
    wr(5'b00011);
    clean_all(); d0 = 19'h4_4444; set_way(2, d0, 25'd1 << 4); set_way(3, 19'h1, 25'd6);
    probe(11'h100, 1, 2, 0, 0);
    chk("R10 no flags", status[1:0], 2'b00);
    chk("R10 no correction", fix_tags[2*TAG_W +: TAG_W], d0 ^ 19'h10);

    // R11 force hit way 4, real hit says way 2
    wr(5'b00100);
    clean_all(); set_way(4, 19'h6_0606, 25'd1 << 9);
    probe(11'h444, 1, 2, 1, 4);
    chk("R11 forced way", status[7:5], 3'd4);
    chk("R11 forced syn nonzero", status[13:8] != 0, 1'b1);
    chk("R9 irq gated off", irq_sbe, 1'b0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      for (int w = 0; w < WAYS; w++) begin
        int r = $urandom % 12;
        int b1 = $urandom % 25;
        int b2 = (b1 + 1 + $urandom % 24) % 25;
        logic [24:0] m = '0;
        if (r == 0) m = 25'd1 << b1;
        else if (r == 1) m = (25'd1 << b1) | (25'd1 << b2);
        set_way(w, 19'($urandom), m);
      end
      probe_vld = ($urandom % 3) != 0;
      probe_idx = 11'($urandom);
      probe_hit = $urandom % 2;
      probe_hit_way = 3'($urandom);
      dbg_force_hit = ($urandom % 8) == 0;
      dbg_way = 3'($urandom);
      cfg_we = ($urandom % 6) == 0;
      cfg_wdata = {2'($urandom), ($urandom % 8) != 0, 2'($urandom)};
    end
    @(negedge clk);
    probe_vld = 0; cfg_we = 0; dbg_force_hit = 0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule